// File: doc/BRIEF.md
# Three-Wire Codec Control Port

This block is the slave side of a three-wire control bus for an audio converter. A host drives a mode line, a serial clock and a serial data line. While the mode line is low the host shifts in one selection byte. Its upper six bits name a device, and its two lowest bits name a register group. While the mode line is high the host shifts in data bytes. The block routes each data byte to the group chosen by the last valid selection. The block decodes the stored bytes into control fields for the converter: oversampling clock ratio, serial input format, DC-cancellation enable, volume, de-emphasis, mute, and separate power switches for the ADC and the DAC.

All three serial lines are resynchronised into the system clock domain, and bits are taken on the rising serial clock edge. Two mode-select inputs choose the operating style. When both are high, the control fields come from static configuration pins and a few fixed values. In that style the serial bus has no effect, and the stored register contents are kept for when register control returns.

Top module: `tw_codec_ctl`

## Requirements
- R1: Serial data is sampled on the rising serial clock edge, most significant bit first. In a selection byte, bits 7:2 are compared with the device address 000101.
- R2: A selection byte with any other device address deselects the block. All later data bytes are ignored until a matching selection byte arrives.
- R3: In a matching selection byte, bits 1:0 = 00 pick the data group and 10 picks the status group. The codes 01 and 11 pick no group, so later data bytes are ignored.
- R4: A selection byte takes effect only if exactly eight bits were clocked before the mode line returns high. With any other bit count, the current selection is unchanged.
- R5: In the data phase, every eighth rising serial clock commits one byte. Several bytes may follow each other in one data phase. No control field changes without a committed byte.
- R6: Status byte bits 5:4 give the clock ratio output o_ratio: 00 = 512x, 01 = 384x, 10 = 256x. The code 11 leaves the ratio unchanged, so o_ratio never shows 11 under register control.
- R7: Status byte bits 3:1 drive o_fmt, and bit 0 drives o_dc_en.
- R8: In the data group, byte bits 7:6 = 00 load o_vol from bits 5:0. Bits 7:6 = 10 load o_deemph from bits 4:3, o_mute from bit 2, and the power bits from bits 1:0. The codes 01 and 11 discard the byte.
- R9: Power bit 1 = 1 turns the ADC off (o_adc_on = 0). Power bit 0 = 1 turns the DAC off (o_dac_on = 0).
- R10: After reset all stored fields are zero, the block is deselected, and both converters are on.
- R11: With ms_a and ms_b both high, the outputs are o_ratio = 10, o_fmt = pin_fmt, o_dc_en = 1, o_vol = 0, o_deemph = {0, pin_deemph}, o_mute = pin_mute, o_adc_on = pin_adc_on and o_dac_on = pin_dac_on. Serial traffic in this style changes no stored field.
- R12: With only one of ms_a and ms_b high, the serial interface works as under register control.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ms_a | input | 1 | Mode-select input A |
| ms_b | input | 1 | Mode-select input B |
| ser_mode | input | 1 | Bus mode line: low = selection phase, high = data phase |
| ser_clk | input | 1 | Bus serial clock |
| ser_data | input | 1 | Bus serial data |
| pin_fmt | input | 3 | Static input format |
| pin_deemph | input | 1 | Static de-emphasis enable |
| pin_mute | input | 1 | Static mute |
| pin_adc_on | input | 1 | Static ADC power |
| pin_dac_on | input | 1 | Static DAC power |
| o_ratio | output | 2 | Clock ratio code |
| o_fmt | output | 3 | Serial input format |
| o_dc_en | output | 1 | DC-cancellation filter enable |
| o_vol | output | 6 | Volume code |
| o_deemph | output | 2 | De-emphasis code |
| o_mute | output | 1 | DAC mute |
| o_adc_on | output | 1 | ADC powered |
| o_dac_on | output | 1 | DAC powered |

## Verification
A wrong selection state stays hidden until the next data byte. It then shows as a field that changes when it should hold, or holds when it should change, a few system clocks after that byte's eighth serial clock. A wrong bit counter appears the same way, as a selection that survives a short byte or a data byte that lands one byte late. The bench therefore follows every selection with a data byte and reads all fields. It repeats those reads after static-style traffic and after a reset, to show that the stored state was or was not touched.

// File: rtl/tw_ctl_pkg.sv
package tw_ctl_pkg;
  typedef enum logic [1:0] {
    GRP_NONE = 2'd0,
    GRP_DATA = 2'd1,
    GRP_STAT = 2'd2
  } grp_e;

  typedef struct packed {
    logic [1:0] ratio;
    logic [2:0] fmt;
    logic       dc_en;
    logic [5:0] vol;
    logic [1:0] deemph;
    logic       mute;
    logic [1:0] pwr_off;
  } ctl_regs_t;

  localparam logic [1:0] SEL_DATA   = 2'b00;
  localparam logic [1:0] SEL_STAT   = 2'b10;
  localparam logic [1:0] SUB_VOL    = 2'b00;
  localparam logic [1:0] SUB_MISC   = 2'b10;
  localparam logic [1:0] RATIO_256  = 2'b10;
  localparam logic [1:0] RATIO_RSVD = 2'b11;
endpackage

// File: rtl/tw_sync.sv
module tw_sync #(
  parameter int W      = 3,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] st [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st[0] <= '0;
    else        st[0] <= d;
  end

  for (genvar g = 1; g < STAGES; g++) begin : g_stage
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) st[g] <= '0;
      else        st[g] <= st[g-1];
    end
  end

  assign q = st[STAGES-1];
endmodule

// File: rtl/tw_shift_rx.sv
module tw_shift_rx #(
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic              mode_lvl,
  input  logic              sck_lvl,
  input  logic              sda_lvl,
  output logic              addr_stb,
  output logic              data_stb,
  output logic [BYTE_W-1:0] byte_o
);
  localparam int CNT_W = $clog2(BYTE_W + 2);
  localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(BYTE_W);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(BYTE_W - 1);
  localparam logic [CNT_W-1:0] CNT_OVER = CNT_W'(BYTE_W + 1);

  logic              mode_q, sck_q;
  logic              mode_rise, mode_edge, sck_rise;
  logic [BYTE_W-1:0] sreg, sreg_nxt, shift_val;
  logic [CNT_W-1:0]  cnt, cnt_nxt;

  assign mode_rise = mode_lvl & ~mode_q;
  assign mode_edge = mode_lvl ^ mode_q;
  assign sck_rise  = sck_lvl & ~sck_q;
  assign shift_val = {sreg[BYTE_W-2:0], sda_lvl};

  always_comb begin
    cnt_nxt  = cnt;
    sreg_nxt = sreg;
    addr_stb = 1'b0;
    data_stb = 1'b0;
    byte_o   = sreg;
    if (!en) begin
      cnt_nxt = '0;
    end else if (mode_edge) begin
      cnt_nxt  = '0;
      addr_stb = mode_rise && (cnt == CNT_FULL);
    end else if (sck_rise) begin
      sreg_nxt = shift_val;
      if (mode_lvl) begin
        if (cnt == CNT_LAST) begin
          cnt_nxt  = '0;
          data_stb = 1'b1;
          byte_o   = shift_val;
        end else begin
          cnt_nxt = cnt + 1'b1;
        end
      end else if (cnt != CNT_OVER) begin
        cnt_nxt = cnt + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= 1'b0;
      sck_q  <= 1'b0;
      cnt    <= '0;
      sreg   <= '0;
    end else begin
      mode_q <= mode_lvl;
      sck_q  <= sck_lvl;
      cnt    <= cnt_nxt;
      sreg   <= sreg_nxt;
    end
  end
endmodule

// File: rtl/tw_reg_bank.sv
module tw_reg_bank
  import tw_ctl_pkg::*;
#(
  parameter int          ADDR_W   = 6,
  parameter logic [ADDR_W-1:0] DEV_ADDR = 6'b000101,
  localparam int         BYTE_W   = ADDR_W + 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              addr_stb,
  input  logic              data_stb,
  input  logic [BYTE_W-1:0] byte_i,
  output ctl_regs_t         regs,
  output grp_e              grp
);
  ctl_regs_t regs_nxt;
  grp_e      grp_nxt;
  logic [1:0] top2;

  assign top2 = byte_i[BYTE_W-1:BYTE_W-2];

  always_comb begin
    grp_nxt = GRP_NONE;
    if (byte_i[BYTE_W-1:2] == DEV_ADDR) begin
      case (byte_i[1:0])
        SEL_DATA: grp_nxt = GRP_DATA;
        SEL_STAT: grp_nxt = GRP_STAT;
        default:  grp_nxt = GRP_NONE;
      endcase
    end
  end

  always_comb begin
    regs_nxt = regs;
    case (grp)
      GRP_STAT: begin
        if (byte_i[5:4] != RATIO_RSVD) regs_nxt.ratio = byte_i[5:4];
        regs_nxt.fmt   = byte_i[3:1];
        regs_nxt.dc_en = byte_i[0];
      end
      GRP_DATA: begin
        if (top2 == SUB_VOL) begin
          regs_nxt.vol = byte_i[5:0];
        end else if (top2 == SUB_MISC) begin
          regs_nxt.deemph  = byte_i[4:3];
          regs_nxt.mute    = byte_i[2];
          regs_nxt.pwr_off = byte_i[1:0];
        end
      end
      default: regs_nxt = regs;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      grp  <= GRP_NONE;
      regs <= '0;
    end else begin
      if (addr_stb) grp  <= grp_nxt;
      if (data_stb) regs <= regs_nxt;
    end
  end
endmodule

// File: rtl/tw_codec_ctl.sv
module tw_codec_ctl
  import tw_ctl_pkg::*;
#(
  parameter int ADDR_W      = 6,
  parameter logic [ADDR_W-1:0] DEV_ADDR = 6'b000101,
  parameter int SYNC_STAGES = 2,
  parameter int RST_STAGES  = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       ms_a,
  input  logic       ms_b,
  input  logic       ser_mode,
  input  logic       ser_clk,
  input  logic       ser_data,
  input  logic [2:0] pin_fmt,
  input  logic       pin_deemph,
  input  logic       pin_mute,
  input  logic       pin_adc_on,
  input  logic       pin_dac_on,
  output logic [1:0] o_ratio,
  output logic [2:0] o_fmt,
  output logic       o_dc_en,
  output logic [5:0] o_vol,
  output logic [1:0] o_deemph,
  output logic       o_mute,
  output logic       o_adc_on,
  output logic       o_dac_on
);
  localparam int BYTE_W = ADDR_W + 2;

  logic [RST_STAGES-1:0] rst_q;
  logic                  rst_core_n;
  logic [2:0]            lines_s;
  logic                  static_mode;
  logic                  addr_stb, data_stb;
  logic [BYTE_W-1:0]     rx_byte;
  ctl_regs_t             rg;
  grp_e                  grp;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_q <= '0;
    else        rst_q <= {rst_q[RST_STAGES-2:0], 1'b1};
  end
  assign rst_core_n = rst_q[RST_STAGES-1];

  assign static_mode = ms_a & ms_b;

  tw_sync #(.W(3), .STAGES(SYNC_STAGES)) i_sync (
    .clk   (clk),
    .rst_n (rst_core_n),
    .d     ({ser_mode, ser_clk, ser_data}),
    .q     (lines_s)
  );

  tw_shift_rx #(.BYTE_W(BYTE_W)) i_rx (
    .clk      (clk),
    .rst_n    (rst_core_n),
    .en       (~static_mode),
    .mode_lvl (lines_s[2]),
    .sck_lvl  (lines_s[1]),
    .sda_lvl  (lines_s[0]),
    .addr_stb (addr_stb),
    .data_stb (data_stb),
    .byte_o   (rx_byte)
  );

  tw_reg_bank #(.ADDR_W(ADDR_W), .DEV_ADDR(DEV_ADDR)) i_bank (
    .clk      (clk),
    .rst_n    (rst_core_n),
    .addr_stb (addr_stb),
    .data_stb (data_stb),
    .byte_i   (rx_byte),
    .regs     (rg),
    .grp      (grp)
  );

  always_comb begin
    if (static_mode) begin
      o_ratio  = RATIO_256;
      o_fmt    = pin_fmt;
      o_dc_en  = 1'b1;
      o_vol    = '0;
      o_deemph = {1'b0, pin_deemph};
      o_mute   = pin_mute;
      o_adc_on = pin_adc_on;
      o_dac_on = pin_dac_on;
    end else begin
      o_ratio  = rg.ratio;
      o_fmt    = rg.fmt;
      o_dc_en  = rg.dc_en;
      o_vol    = rg.vol;
      o_deemph = rg.deemph;
      o_mute   = rg.mute;
      o_adc_on = ~rg.pwr_off[1];
      o_dac_on = ~rg.pwr_off[0];
    end
  end
endmodule

// File: rtl/tw_codec_ctl_chk.sv
module tw_codec_ctl_chk (
  input logic       clk,
  input logic       rst_core_n,
  input logic       static_mode,
  input logic       data_stb,
  input logic [1:0] grp,
  input logic [2:0] pin_fmt,
  input logic       pin_mute,
  input logic [1:0] o_ratio,
  input logic [2:0] o_fmt,
  input logic       o_dc_en,
  input logic [5:0] o_vol,
  input logic [1:0] o_deemph,
  input logic       o_mute,
  input logic       o_adc_on,
  input logic       o_dac_on
);
  logic seen;

  always_ff @(posedge clk or negedge rst_core_n) begin
    if (!rst_core_n) seen <= 1'b0;
    else             seen <= 1'b1;
  end

  AST_RATIO_LEGAL: assert property (@(posedge clk) disable iff (!rst_core_n)
    !static_mode |-> o_ratio != 2'b11); // R6

  AST_STATIC_MAP: assert property (@(posedge clk) disable iff (!rst_core_n)
    static_mode |-> (o_vol == 6'd0 && o_ratio == 2'b10 && o_dc_en &&
                     o_mute == pin_mute && o_fmt == pin_fmt)); // R11

  AST_WRITE_NEEDS_STROBE: assert property (@(posedge clk) disable iff (!rst_core_n)
    (seen && !static_mode && !$past(static_mode) && !$past(data_stb)) |->
    ($stable(o_vol) && $stable(o_fmt) && $stable(o_mute) && $stable(o_deemph) &&
     $stable(o_adc_on) && $stable(o_dac_on) && $stable(o_ratio) && $stable(o_dc_en))); // R5

  AST_NO_WRITE_DESEL: assert property (@(posedge clk) disable iff (!rst_core_n)
    (data_stb && grp == 2'd0 && !static_mode) |=>
    (static_mode || ($stable(o_vol) && $stable(o_fmt) && $stable(o_mute) &&
                     $stable(o_ratio) && $stable(o_dc_en)))); // R2

  AST_RESET_STATE: assert property (@(posedge clk) disable iff (!rst_core_n)
    (!seen && !static_mode) |-> (o_vol == 6'd0 && o_ratio == 2'b00 && !o_mute &&
                                 o_adc_on && o_dac_on)); // R10
endmodule

bind tw_codec_ctl tw_codec_ctl_chk i_chk (
  .clk         (clk),
  .rst_core_n  (rst_core_n),
  .static_mode (static_mode),
  .data_stb    (data_stb),
  .grp         (grp),
  .pin_fmt     (pin_fmt),
  .pin_mute    (pin_mute),
  .o_ratio     (o_ratio),
  .o_fmt       (o_fmt),
  .o_dc_en     (o_dc_en),
  .o_vol       (o_vol),
  .o_deemph    (o_deemph),
  .o_mute      (o_mute),
  .o_adc_on    (o_adc_on),
  .o_dac_on    (o_dac_on)
);

// File: tb/test_tw_codec_ctl.sv
module test_tw_codec_ctl;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       ms_a = 1'b0, ms_b = 1'b0;
  logic       ser_mode = 1'b1, ser_clk = 1'b0, ser_data = 1'b0;
  logic [2:0] pin_fmt = 3'd0;
  logic       pin_deemph = 1'b0, pin_mute = 1'b0, pin_adc_on = 1'b1, pin_dac_on = 1'b1;
  logic [1:0] o_ratio;
  logic [2:0] o_fmt;
  logic       o_dc_en;
  logic [5:0] o_vol;
  logic [1:0] o_deemph;
  logic       o_mute, o_adc_on, o_dac_on;

  int checks = 0;
  int bad = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  tw_codec_ctl i_tw_codec_ctl (
    .clk(clk), .rst_n(rst_n), .ms_a(ms_a), .ms_b(ms_b),
    .ser_mode(ser_mode), .ser_clk(ser_clk), .ser_data(ser_data),
    .pin_fmt(pin_fmt), .pin_deemph(pin_deemph), .pin_mute(pin_mute),
    .pin_adc_on(pin_adc_on), .pin_dac_on(pin_dac_on),
    .o_ratio(o_ratio), .o_fmt(o_fmt), .o_dc_en(o_dc_en), .o_vol(o_vol),
    .o_deemph(o_deemph), .o_mute(o_mute), .o_adc_on(o_adc_on), .o_dac_on(o_dac_on)
  );

  typedef struct packed {
    logic [7:0] a;
    logic [7:0] d;
    logic [1:0] ratio;
    logic [2:0] fmt;
    logic       dc;
    logic [5:0] vol;
    logic [1:0] de;
    logic       m;
    logic       adc;
    logic       dac;
    logic [3:0] req;
  } vec_t;

  localparam vec_t TBL [12] = '{
    '{8'h16, 8'h1B, 2'd1, 3'd5, 1'b1, 6'd0,  2'd0, 1'b0, 1'b1, 1'b1, 4'd7},
    '{8'h14, 8'h2A, 2'd1, 3'd5, 1'b1, 6'd42, 2'd0, 1'b0, 1'b1, 1'b1, 4'd8},
    '{8'h14, 8'h9D, 2'd1, 3'd5, 1'b1, 6'd42, 2'd3, 1'b1, 1'b1, 1'b0, 4'd9},
    '{8'h24, 8'h3F, 2'd1, 3'd5, 1'b1, 6'd42, 2'd3, 1'b1, 1'b1, 1'b0, 4'd2},
    '{8'h14, 8'h40, 2'd1, 3'd5, 1'b1, 6'd42, 2'd3, 1'b1, 1'b1, 1'b0, 4'd8},
    '{8'h15, 8'h05, 2'd1, 3'd5, 1'b1, 6'd42, 2'd3, 1'b1, 1'b1, 1'b0, 4'd3},
    '{8'h16, 8'h30, 2'd1, 3'd0, 1'b0, 6'd42, 2'd3, 1'b1, 1'b1, 1'b0, 4'd6},
    '{8'h16, 8'h20, 2'd2, 3'd0, 1'b0, 6'd42, 2'd3, 1'b1, 1'b1, 1'b0, 4'd6},
    '{8'h14, 8'hC1, 2'd2, 3'd0, 1'b0, 6'd42, 2'd3, 1'b1, 1'b1, 1'b0, 4'd8},
    '{8'h14, 8'h82, 2'd2, 3'd0, 1'b0, 6'd42, 2'd0, 1'b0, 1'b0, 1'b1, 4'd9},
    '{8'h14, 8'h3F, 2'd2, 3'd0, 1'b0, 6'd63, 2'd0, 1'b0, 1'b0, 1'b1, 4'd1},
    '{8'h16, 8'h0E, 2'd0, 3'd7, 1'b0, 6'd63, 2'd0, 1'b0, 1'b0, 1'b1, 4'd7}
  };

  function automatic string tag(input logic [3:0] n);
    case (n)
      4'd1:    return "R1";
      4'd2:    return "R2";
      4'd3:    return "R3";
      4'd6:    return "R6";
      4'd7:    return "R7";
      4'd8:    return "R8";
      default: return "R9";
    endcase
  endfunction

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string req, input string fld, input int act, input int exp);
    checks++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, fld, act, exp);
    end
  endtask

  task automatic chk_all(input string req, input int ratio, input int fmt, input int dc,
                         input int vol, input int de, input int m, input int adc, input int dac);
    chk(req, "ratio", int'(o_ratio), ratio);
    chk(req, "fmt", int'(o_fmt), fmt);
    chk(req, "dc_en", int'(o_dc_en), dc);
    chk(req, "vol", int'(o_vol), vol);
    chk(req, "deemph", int'(o_deemph), de);
    chk(req, "mute", int'(o_mute), m);
    chk(req, "adc_on", int'(o_adc_on), adc);
    chk(req, "dac_on", int'(o_dac_on), dac);
  endtask

  task automatic send_bits(input logic [7:0] b, input int nbits);
    for (int i = 7; i >= 8 - nbits; i--) begin
      ser_data = b[i];
      tick(3);
      ser_clk = 1'b1;
      tick(3);
      ser_clk = 1'b0;
    end
  endtask

  task automatic sel_byte(input logic [7:0] b, input int nbits);
    ser_mode = 1'b0;
    tick(4);
    send_bits(b, nbits);
    tick(4);
    ser_mode = 1'b1;
    tick(5);
  endtask

  task automatic data_byte(input logic [7:0] b);
    send_bits(b, 8);
    tick(6);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      bad++;
      checks++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", checks, bad);
      $finish;
    end
  end

  initial begin
    tick(5);
    rst_n = 1'b1;
    tick(8);
    // R10: reset values, both converters on
    chk_all("R10", 0, 0, 0, 0, 0, 0, 1, 1);

    // Table walk: R1 R2 R3 R6 R7 R8 R9
    for (int k = 0; k < 12; k++) begin
      sel_byte(TBL[k].a, 8);
      data_byte(TBL[k].d);
      chk_all(tag(TBL[k].req), int'(TBL[k].ratio), int'(TBL[k].fmt), int'(TBL[k].dc),
              int'(TBL[k].vol), int'(TBL[k].de), int'(TBL[k].m), int'(TBL[k].adc),
              int'(TBL[k].dac));
    end

    // R11: static style mapping
    pin_fmt = 3'd3; pin_deemph = 1'b1; pin_mute = 1'b1; pin_adc_on = 1'b0; pin_dac_on = 1'b1;
    ms_a = 1'b1; ms_b = 1'b1;
    tick(2);
    chk_all("R11", 2, 3, 1, 0, 1, 1, 0, 1);
    // R11: serial traffic in static style is ignored
    sel_byte(8'h14, 8);
    data_byte(8'h15);
    chk_all("R11", 2, 3, 1, 0, 1, 1, 0, 1);
    ms_b = 1'b0;
    tick(2);
    chk_all("R11", 0, 7, 0, 63, 0, 0, 0, 1);

    // R12: one mode-select high keeps the serial interface active
    sel_byte(8'h14, 8);
    data_byte(8'h07);
    chk_all("R12", 0, 7, 0, 7, 0, 0, 0, 1);
    ms_a = 1'b0;

    // R4: a short mismatching selection byte keeps the data group
    sel_byte(8'h24, 7);
    data_byte(8'h11);
    chk_all("R4", 0, 7, 0, 17, 0, 0, 0, 1);

    // R5: two data bytes in one data phase
    sel_byte(8'h14, 8);
    data_byte(8'h05);
    chk("R5", "vol", int'(o_vol), 5);
    data_byte(8'h8C);
    chk_all("R5", 0, 7, 0, 5, 1, 1, 1, 1);

    // R10: reset mid-run, then data without selection stays ignored
    rst_n = 1'b0;
    tick(3);
    rst_n = 1'b1;
    tick(8);
    chk_all("R10", 0, 0, 0, 0, 0, 0, 1, 1);
    data_byte(8'h2A);
    chk_all("R10", 0, 0, 0, 0, 0, 0, 1, 1);

    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", checks, bad);
    $finish;
  end
endmodule